// File: doc/BRIEF.md
# Pseudo-Random Noise Voice

This block is the noise voice of a sound generator. A down-counting period timer steps a 15-bit feedback shift register. The register's low bit gates a 4-bit loudness value on its way to the mixer. The timer's interval is chosen by a 4-bit index into a fixed, non-linear table of sixteen periods. A mode flag moves the second feedback tap, so the register produces either a long pseudo-random sequence or a very short, buzzy one.

Software drives the voice through three write-only byte registers on a 2-bit address bus, and each write is a single-cycle strobe:

- Address 2 holds the mode and the period index.
- Address 0 holds a length-hold flag and a 5-bit envelope setting.
- Address 3 holds a 5-bit length-load index.

The fields at addresses 0 and 3 belong to an envelope unit and a length counter that sit outside this block. They are handed on as held values and one-cycle strobes. The loudness and a "length exhausted" flag come back in from those units.

Top module: `noise_channel`

## Requirements
- R1: While reset is asserted, and until the first shift step after reset, the shift register holds 1. So `sample_o` is 0 for any loudness, and `hold_o`, `env_cfg_o`, `len_idx_o` and both strobes are 0.
- R2: `step_o` pulses once every P clock cycles, where P is entry `period_idx` of the table 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068 (index 0 first).
- R3: A new period index does not shorten or lengthen the interval already running. It applies from the next reload, which happens on a `step_o` cycle.
- R4: With mode 0, each step writes bit0 XOR bit1 into bit 14 and shifts the other bits right by one. Starting from 1, the state returns to 1 after exactly 32767 steps.
- R5: With mode 1, the feedback is bit0 XOR bit6, and the resulting sequence repeats every 93 steps.
- R6: A mode write does not reload the shift register. Stepping continues from the state held at the moment of the switch.
- R7: `sample_o` equals `volume_i`, except that it is 0 when shift-register bit 0 is 1 or when `len_zero_i` is 1.
- R8: The address-2 byte takes the mode from bit 7 and the period index from bits 3..0. Bits 6..4 are ignored.
- R9: A write to address 0 sets `hold_o` from bit 5 and `env_cfg_o` from bits 4..0. `env_wr_o` pulses for one cycle, in the cycle after the write.
- R10: A write to address 3 sets `len_idx_o` from bits 7..3. `len_load_o`, which also serves as the envelope restart request, pulses for one cycle, in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and timer |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data byte |
| volume_i | input | 4 | Loudness from the envelope unit |
| len_zero_i | input | 1 | Length counter has reached zero |
| sample_o | output | 4 | Gated loudness to the mixer |
| step_o | output | 1 | Pulses in the cycle at whose end the register shifts |
| hold_o | output | 1 | Length-hold flag |
| env_cfg_o | output | 5 | Envelope setting |
| env_wr_o | output | 1 | Envelope setting written |
| len_idx_o | output | 5 | Length-load index |
| len_load_o | output | 1 | Length load and envelope restart request |

## Verification
The bench follows the whole long sequence from reset and compares the gated output against its own model at every cycle. A wrong tap or shift direction would break the match within a few steps, and a wrong width would miss the 32767-step return to 1. It then switches to the short mode without resetting and checks the 93-step repeat from that state; a design that reloaded on the mode write would drift from the model. It measures every table period with junk in the ignored bits, and checks that a period written mid-interval leaves the current interval untouched. A timer that reloaded at once would show the new gap one interval too early.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int IDX_W = 4;
  localparam int CNT_W = 12;
  localparam int SR_W  = 15;
  localparam int VOL_W = 4;
  localparam int ENV_W = 5;
  localparam int LEN_W = 5;

  // Timer interval per period index (non-linear table)
  function automatic logic [CNT_W-1:0] period_of(input logic [IDX_W-1:0] i);
    logic [CNT_W-1:0] p;
    case (i)
      4'd0:    p = 12'd4;
      4'd1:    p = 12'd8;
      4'd2:    p = 12'd16;
      4'd3:    p = 12'd32;
      4'd4:    p = 12'd64;
      4'd5:    p = 12'd96;
      4'd6:    p = 12'd128;
      4'd7:    p = 12'd160;
      4'd8:    p = 12'd202;
      4'd9:    p = 12'd254;
      4'd10:   p = 12'd380;
      4'd11:   p = 12'd508;
      4'd12:   p = 12'd762;
      4'd13:   p = 12'd1016;
      4'd14:   p = 12'd2034;
      default: p = 12'd4068;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/noise_regs.sv
module noise_regs
  import noise_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic             mode,
  output logic [IDX_W-1:0] period_idx,
  output logic             hold,
  output logic [ENV_W-1:0] env_cfg,
  output logic             env_wr,
  output logic [LEN_W-1:0] len_idx,
  output logic             len_load
);
  localparam logic [1:0] A_ENV   = 2'd0;
  localparam logic [1:0] A_SHAPE = 2'd2;
  localparam logic [1:0] A_LEN   = 2'd3;

  logic             mode_d, hold_d, env_wr_d, len_load_d;
  logic [IDX_W-1:0] idx_d;
  logic [ENV_W-1:0] env_d;
  logic [LEN_W-1:0] len_d;
  logic             sel_env, sel_shape, sel_len;

  always_comb begin
    sel_env    = wr_en && (wr_addr == A_ENV);
    sel_shape  = wr_en && (wr_addr == A_SHAPE);
    sel_len    = wr_en && (wr_addr == A_LEN);
    mode_d     = sel_shape ? wr_data[7]         : mode;
    idx_d      = sel_shape ? wr_data[IDX_W-1:0] : period_idx;
    hold_d     = sel_env   ? wr_data[5]         : hold;
    env_d      = sel_env   ? wr_data[ENV_W-1:0] : env_cfg;
    len_d      = sel_len   ? wr_data[7:8-LEN_W] : len_idx;
    env_wr_d   = sel_env;
    len_load_d = sel_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= 1'b0;
      period_idx <= '0;
      hold       <= 1'b0;
      env_cfg    <= '0;
      env_wr     <= 1'b0;
      len_idx    <= '0;
      len_load   <= 1'b0;
    end else begin
      mode       <= mode_d;
      period_idx <= idx_d;
      hold       <= hold_d;
      env_cfg    <= env_d;
      env_wr     <= env_wr_d;
      len_idx    <= len_d;
      len_load   <= len_load_d;
    end
  end

  assert_env_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    env_wr |-> $past(wr_en && wr_addr == A_ENV));
  assert_len_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    len_load |-> $past(wr_en && wr_addr == A_LEN));
endmodule

// File: rtl/noise_timer.sv
module noise_timer
  import noise_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] period_idx,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, reload_val;

  always_comb begin
    reload_val = period_of(period_idx) - CNT_W'(1);
    tick       = (cnt_q == '0);
    cnt_d      = tick ? reload_val : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= period_of('0) - CNT_W'(1);
    else        cnt_q <= cnt_d;
  end

  // R3: reload only samples the index on a tick
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == $past(period_of(period_idx)) - CNT_W'(1));
  assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
  import noise_pkg::*;
#(
  parameter int LONG_TAP  = 1,
  parameter int SHORT_TAP = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            mode,
  output logic [SR_W-1:0] state
);
  logic [SR_W-1:0] state_d;
  logic            fb;

  always_comb begin
    fb      = state[0] ^ (mode ? state[SHORT_TAP] : state[LONG_TAP]);
    state_d = step ? {fb, state[SR_W-1:1]} : state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SR_W'(1);
    else        state <= state_d;
  end

  assert_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> state[SR_W-2:0] == $past(state[SR_W-1:1]));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));
endmodule

// File: rtl/noise_channel.sv
module noise_channel
  import noise_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [VOL_W-1:0] volume_i,
  input  logic             len_zero_i,
  output logic [VOL_W-1:0] sample_o,
  output logic             step_o,
  output logic             hold_o,
  output logic [ENV_W-1:0] env_cfg_o,
  output logic             env_wr_o,
  output logic [LEN_W-1:0] len_idx_o,
  output logic             len_load_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             mode;
  logic [IDX_W-1:0] period_idx;
  logic             tick;
  logic [SR_W-1:0]  sr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  noise_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode(mode), .period_idx(period_idx),
    .hold(hold_o), .env_cfg(env_cfg_o), .env_wr(env_wr_o),
    .len_idx(len_idx_o), .len_load(len_load_o)
  );

  noise_timer u_timer (
    .clk(clk), .rst_n(rst_int_n), .period_idx(period_idx), .tick(tick)
  );

  noise_lfsr #(.LONG_TAP(1), .SHORT_TAP(6)) u_lfsr (
    .clk(clk), .rst_n(rst_int_n), .step(tick), .mode(mode), .state(sr)
  );

  always_comb begin
    step_o   = tick;
    sample_o = (sr[0] || len_zero_i) ? '0 : volume_i;
  end

  always_comb begin
    if (rst_int_n && len_zero_i)
      assert_gate_len_R7: assert (sample_o == '0);
  end
  assert_gate_bit_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sample_o != '0) |-> (sample_o == volume_i));
endmodule

// File: tb/sim_noise_channel.sv
module sim_noise_channel;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] volume_i;
  logic       len_zero_i;
  logic [3:0] sample_o;
  logic       step_o, hold_o, env_wr_o, len_load_o;
  logic [4:0] env_cfg_o, len_idx_o;

  noise_channel u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .volume_i(volume_i), .len_zero_i(len_zero_i),
    .sample_o(sample_o), .step_o(step_o), .hold_o(hold_o),
    .env_cfg_o(env_cfg_o), .env_wr_o(env_wr_o), .len_idx_o(len_idx_o),
    .len_load_o(len_load_o)
  );

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [14:0] m;           // bench model of the shift register
  bit          m_mode;
  int          steps = 0;
  int          cyc = 0, last_step = 0, gap = 0;
  bit          mon_en = 0;

  // period table from R2, index 0 first
  localparam int PER [16] = '{4, 8, 16, 32, 64, 96, 128, 160,
                              202, 254, 380, 508, 762, 1016, 2034, 4068};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle monitor: output gate (R7) and sequence (R4/R5) against the model
  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      check(sample_o == ((m[0] || len_zero_i) ? 4'd0 : volume_i), "R7/R4/R5 sample",
            sample_o, (m[0] || len_zero_i) ? 0 : volume_i);
      if (step_o) begin
        m = {m[0] ^ (m_mode ? m[6] : m[1]), m[14:1]};
        steps++;
        gap = cyc - last_step;
        last_step = cyc;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    if (a == 2'd2) m_mode = d[7];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_steps(input int n);
    int target;
    target = steps + n;
    while (steps < target) @(posedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [14:0] snap;
    int first_ret;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    volume_i = 4'hA; len_zero_i = 1'b0;
    m = 15'd1; m_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sample_o == 4'd0, "R1 sample in reset", sample_o, 0);
    check({hold_o, env_cfg_o, env_wr_o, len_idx_o, len_load_o} == '0,
          "R1 pass-through outputs", {hold_o, env_cfg_o, len_idx_o}, 0);
    rst_n = 1'b1;
    mon_en = 1;

    // R4: full long sequence from reset, idx 0, mode 0
    first_ret = 0;
    for (int s = 1; s <= 32767; s++) begin
      wait_steps(1);
      if (m == 15'd1 && first_ret == 0) first_ret = s;
    end
    check(first_ret == 32767, "R4 long sequence length", first_ret, 32767);
    check(gap == 4, "R2 period idx0", gap, 4);

    // R9 / R10: pass-through fields
    wr(2'd0, 8'b1011_0110);
    check(env_wr_o == 1'b1, "R9 env strobe", env_wr_o, 1);
    check(hold_o == 1'b1 && env_cfg_o == 5'b10110, "R9 env fields", {hold_o, env_cfg_o}, 6'b110110);
    @(negedge clk);
    check(env_wr_o == 1'b0, "R9 strobe one cycle", env_wr_o, 0);
    wr(2'd3, 8'b1101_0101);
    check(len_load_o == 1'b1 && len_idx_o == 5'b11010, "R10 length load",
          {len_load_o, len_idx_o}, 6'b111010);
    @(negedge clk);
    check(len_load_o == 1'b0, "R10 strobe one cycle", len_load_o, 0);

    // R6 / R5: switch to short mode without reset, check 93-step repeat
    wr(2'd2, 8'h80);
    wait_steps(5);
    snap = m;
    first_ret = 0;
    for (int s = 1; s <= 93; s++) begin
      wait_steps(1);
      if (m == snap && first_ret == 0) first_ret = s;
    end
    check(first_ret == 93, "R5/R6 short sequence length", first_ret, 93);

    // R2 / R8: walk the period table, junk in ignored bits 6..4
    for (int i = 0; i < 16; i++) begin
      wr(2'd2, {1'b1, 3'b101, 4'(i)});
      wait_steps(2);
      check(gap == PER[i], "R2/R8 period", gap, PER[i]);
    end
    check(m_mode == 1'b1, "R8 mode kept", m_mode, 1);

    // R3: period written mid-interval applies from next reload only
    wait_steps(1);
    wr(2'd2, 8'h80);
    wait_steps(1);
    check(gap == 4068, "R3 running interval kept", gap, 4068);
    wait_steps(1);
    check(gap == 4, "R3 new interval applied", gap, 4);

    // R7: gating by length flag and by loudness values
    len_zero_i = 1'b1;
    wait_steps(10);
    len_zero_i = 1'b0;
    volume_i = 4'hF;
    wait_steps(20);
    volume_i = 4'h0;
    wait_steps(5);
    volume_i = 4'h7;
    wait_steps(20);

    // R1: reset again restores state 1 (sample 0 for any loudness)
    mon_en = 0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(sample_o == 4'd0 && hold_o == 1'b0, "R1 re-reset", sample_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sample_o == 4'd0, "R1 state 1 after reset", sample_o, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule